// File: doc/BRIEF.md
# Precision Palette Write Port with Auto-Increment

This block sits in front of a colour palette RAM in a display pipe. A host loads the RAM through two write strobes that share one data bus. The first strobe writes an index register, which holds an address, a flag that makes the address step forward by itself and a flag that splits the table into two regions. The second strobe writes one palette entry at the current address. Each entry holds three 10-bit colour channels. A legacy mode accepts narrower 8:8:8 words instead.

When the table is split, the lower region holds the degamma curve and the upper region holds the gamma curve. The upper region starts at an address equal to the degamma size. Auto-increment stays inside whichever region the address is in and wraps to the start of that region. Three per-channel maximum registers give the output for pixels whose input lies above 1.0.

A pixel-side port looks up one entry per request and returns it one cycle later, widened to 16 bits per channel. If the request is flagged as above range, the port returns the channel maxima instead of the entry.

Top module: `palette_port`

## Requirements
- R1: In normal mode a data word is stored as red = bits 29:20, green = bits 19:10 and blue = bits 9:0, and bits 31:30 are ignored. A looked-up 10-bit channel v is returned as the 16-bit value {v, v[9:4]}.
- R2: The index register is written through `wdata`, with bit 31 as the split flag, bit 30 as the auto-increment flag and the low bits as the address. A write with bit 30 clear loads the address. With auto-increment set, each data write moves the address up by one. With auto-increment clear, the address does not move.
- R3: An index write with bit 30 set updates both flags but leaves the stored address unchanged, whatever the address bits carry.
- R4: In split mode the degamma region covers addresses 0 to DEG_SIZE-1 and the gamma region covers DEG_SIZE to DEPTH-1. Addresses are absolute.
- R5: When auto-increment is on and a data write lands on the last address of the active region, the address returns to the first address of that region. The active region is the whole table when split is off.
- R6: An index write of all zeros clears both flags and sets the address to 0.
- R7: The three 16-bit maxima reset to 0xFFFF. `max_sel` 0, 1 and 2 select red, green and blue; 3 writes nothing. A lookup with `pix_over` set returns the maxima in place of the entry.
- R8: With `legacy_mode` high, data words are taken as red = bits 23:16, green = 15:8 and blue = 7:0. Each 8-bit value u is stored as {u, u[7:6]}. The split flag has no effect on addressing in this mode.
- R9: A lookup requested in one cycle gives `pix_valid` high and its data in the next cycle. Without a request, `pix_valid` is low in the next cycle.
- R10: A lookup of the address being written in the same cycle returns the data held before that write.
- R11: After reset the address is 0, both flags are clear and `pix_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| legacy_mode | input | 1 | Selects 8:8:8 data words and whole-table addressing |
| idx_we | input | 1 | Write strobe for the index register |
| data_we | input | 1 | Write strobe for one palette entry at the current address |
| max_we | input | 1 | Write strobe for a channel maximum |
| max_sel | input | 2 | Channel maximum chosen by `max_we` |
| wdata | input | 32 | Shared host write data |
| host_index | output | IDX_W | Current palette address |
| pix_req | input | 1 | Pixel-side lookup request |
| pix_addr | input | IDX_W | Pixel-side lookup address |
| pix_over | input | 1 | Pixel input lies above 1.0 |
| pix_valid | output | 1 | Lookup result valid |
| pix_red | output | 16 | Red result |
| pix_green | output | 16 | Green result |
| pix_blue | output | 16 | Blue result |

## Verification
The hardest states to reach are the two region wraps and the interaction between the auto-increment quirk and them. An index write that turns on auto-increment cannot also set the address, so every wrap test takes two index writes: first the address at the edge of a region with auto-increment off, then the flags with the address bits ignored. A single data write then shows whether the address wraps to 0, wraps to DEG_SIZE or simply moves on when legacy mode overrides the split. The read-during-write case needs the host strobe and the pixel request to be driven in the same cycle on the same address.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int CH_W  = 10;
  localparam int OUT_W = 16;

  typedef struct packed {
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
  } pal_entry_t;

  // 8-bit legacy channel widened to 10 bits by replicating its top bits
  function automatic logic [CH_W-1:0] from_legacy(input logic [7:0] u);
    return {u, u[7:6]};
  endfunction

  function automatic pal_entry_t unpack_word(input logic [31:0] w, input logic legacy);
    pal_entry_t e;
    if (legacy) begin
      e.r = from_legacy(w[23:16]);
      e.g = from_legacy(w[15:8]);
      e.b = from_legacy(w[7:0]);
    end else begin
      e.r = w[29:20];
      e.g = w[19:10];
      e.b = w[9:0];
    end
    return e;
  endfunction

  function automatic logic [OUT_W-1:0] widen(input logic [CH_W-1:0] v);
    return {v, v[CH_W-1:CH_W-6]};
  endfunction
endpackage

// File: rtl/pal_index_ctrl.sv
module pal_index_ctrl #(
  parameter int DEPTH    = 256,
  parameter int DEG_SIZE = 128,
  localparam int IDX_W   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             legacy_mode,
  input  logic             idx_we,
  input  logic             data_we,
  input  logic [31:0]      wdata,
  output logic [IDX_W-1:0] idx_q
);
  localparam logic [IDX_W-1:0] TBL_LAST  = IDX_W'(DEPTH - 1);
  localparam logic [IDX_W-1:0] DEG_LAST  = IDX_W'(DEG_SIZE - 1);
  localparam logic [IDX_W-1:0] GAM_FIRST = IDX_W'(DEG_SIZE);
  localparam int SPLIT_BIT = 31;
  localparam int AUTO_BIT  = 30;

  logic             split_q, auto_q;
  logic             split_d, auto_d;
  logic [IDX_W-1:0] idx_d;
  logic             idx_en, flag_en;
  logic             split_live, in_gamma;
  logic [IDX_W-1:0] reg_first, reg_last, stepped;

  // region selection and stepping
  always_comb begin
    split_live = split_q & ~legacy_mode;
    in_gamma   = split_live & (idx_q >= GAM_FIRST);
    reg_first  = in_gamma ? GAM_FIRST : '0;
    reg_last   = (split_live & ~in_gamma) ? DEG_LAST : TBL_LAST;
    stepped    = (idx_q == reg_last) ? reg_first : idx_q + IDX_W'(1);
  end

  // next state
  always_comb begin
    flag_en = idx_we;
    idx_en  = idx_we | (data_we & auto_q);
    split_d = wdata[SPLIT_BIT];
    auto_d  = wdata[AUTO_BIT];
    if (idx_we) idx_d = wdata[AUTO_BIT] ? idx_q : wdata[IDX_W-1:0];
    else        idx_d = stepped;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      split_q <= 1'b0;
      auto_q  <= 1'b0;
      idx_q   <= '0;
    end else begin
      if (flag_en) begin
        split_q <= split_d;
        auto_q  <= auto_d;
      end
      if (idx_en) idx_q <= idx_d;
    end
  end

  p_hold_on_auto_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_we && wdata[AUTO_BIT]) |=> (idx_q == $past(idx_q)));

  p_zero_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_we && wdata == 32'h0) |=> (idx_q == '0 && !auto_q && !split_q));

  p_no_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && !idx_we && !auto_q) |=> $stable(idx_q));

  p_deg_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && !idx_we && auto_q && split_q && !legacy_mode && idx_q == DEG_LAST)
      |=> (idx_q == '0));
endmodule

// File: rtl/pal_ram.sv
module pal_ram #(
  parameter int DEPTH  = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [IDX_W-1:0]    waddr,
  input  pal_pkg::pal_entry_t wentry,
  input  logic                re,
  input  logic [IDX_W-1:0]    raddr,
  output pal_pkg::pal_entry_t rentry
);
  pal_pkg::pal_entry_t mem [DEPTH];

  // storage: no reset, write on strobe
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wentry;
  end

  // read register: samples the contents held before a same-cycle write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rentry <= '0;
    else if (re) rentry <= mem[raddr];
  end
endmodule

// File: rtl/pal_pixel_out.sv
module pal_pixel_out (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pix_req,
  input  logic                pix_over,
  input  pal_pkg::pal_entry_t rentry,
  input  logic                max_we,
  input  logic [1:0]          max_sel,
  input  logic [15:0]         max_wdata,
  output logic                pix_valid,
  output logic [15:0]         pix_red,
  output logic [15:0]         pix_green,
  output logic [15:0]         pix_blue
);
  localparam int NCH = 3;

  logic        over_q;
  logic [15:0] max_q [NCH];
  logic [9:0]  ch    [NCH];
  logic [15:0] res   [NCH];

  always_comb begin
    ch[0] = rentry.r;
    ch[1] = rentry.g;
    ch[2] = rentry.b;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic max_en;
    always_comb begin
      max_en = max_we & (max_sel == 2'(c));
      res[c] = over_q ? max_q[c] : pal_pkg::widen(ch[c]);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      max_q[c] <= 16'hFFFF;
      else if (max_en) max_q[c] <= max_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_valid <= 1'b0;
      over_q    <= 1'b0;
    end else begin
      pix_valid <= pix_req;
      if (pix_req) over_q <= pix_over;
    end
  end

  assign pix_red   = res[0];
  assign pix_green = res[1];
  assign pix_blue  = res[2];

  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pix_req |=> pix_valid);

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_req |=> !pix_valid);

  p_max_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !max_we |=> ($stable(max_q[0]) && $stable(max_q[1]) && $stable(max_q[2])));
endmodule

// File: rtl/palette_port.sv
module palette_port #(
  parameter int DEPTH    = 256,
  parameter int DEG_SIZE = 128,
  localparam int IDX_W   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             legacy_mode,
  input  logic             idx_we,
  input  logic             data_we,
  input  logic             max_we,
  input  logic [1:0]       max_sel,
  input  logic [31:0]      wdata,
  output logic [IDX_W-1:0] host_index,
  input  logic             pix_req,
  input  logic [IDX_W-1:0] pix_addr,
  input  logic             pix_over,
  output logic             pix_valid,
  output logic [15:0]      pix_red,
  output logic [15:0]      pix_green,
  output logic [15:0]      pix_blue
);
  logic [1:0]          rsync_q;
  logic                rst_ni;
  pal_pkg::pal_entry_t wentry, rentry;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  assign wentry = pal_pkg::unpack_word(wdata, legacy_mode);

  pal_index_ctrl #(.DEPTH(DEPTH), .DEG_SIZE(DEG_SIZE)) u_idx (
    .clk        (clk),
    .rst_n      (rst_ni),
    .legacy_mode(legacy_mode),
    .idx_we     (idx_we),
    .data_we    (data_we),
    .wdata      (wdata),
    .idx_q      (host_index)
  );

  pal_ram #(.DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .rst_n (rst_ni),
    .we    (data_we),
    .waddr (host_index),
    .wentry(wentry),
    .re    (pix_req),
    .raddr (pix_addr),
    .rentry(rentry)
  );

  pal_pixel_out u_pix (
    .clk      (clk),
    .rst_n    (rst_ni),
    .pix_req  (pix_req),
    .pix_over (pix_over),
    .rentry   (rentry),
    .max_we   (max_we),
    .max_sel  (max_sel),
    .max_wdata(wdata[15:0]),
    .pix_valid(pix_valid),
    .pix_red  (pix_red),
    .pix_green(pix_green),
    .pix_blue (pix_blue)
  );

  p_reset_state_r11: assert property (@(posedge clk)
    !rst_ni |=> (host_index == '0 && !pix_valid));
endmodule

// File: tb/test_palette_port.sv
module test_palette_port;
  localparam int DEPTH = 256;
  localparam int DEG   = 128;
  localparam int IW    = $clog2(DEPTH);
  localparam int NV    = 6;
  localparam logic [31:0] VEC [NV] = '{
    32'h3FFF_FFFF, 32'h0000_0000, 32'h0010_0401,
    32'hC000_0000, 32'h2AA5_5555, 32'h1234_5678
  };

  logic clk = 1'b0;
  logic rst_n, legacy_mode, idx_we, data_we, max_we, pix_req, pix_over;
  logic [1:0] max_sel;
  logic [31:0] wdata;
  logic [IW-1:0] pix_addr, host_index;
  logic pix_valid;
  logic [15:0] pix_red, pix_green, pix_blue;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  palette_port #(.DEPTH(DEPTH), .DEG_SIZE(DEG)) i_palette_port (
    .clk(clk), .rst_n(rst_n), .legacy_mode(legacy_mode), .idx_we(idx_we),
    .data_we(data_we), .max_we(max_we), .max_sel(max_sel), .wdata(wdata),
    .host_index(host_index), .pix_req(pix_req), .pix_addr(pix_addr),
    .pix_over(pix_over), .pix_valid(pix_valid), .pix_red(pix_red),
    .pix_green(pix_green), .pix_blue(pix_blue)
  );

  function automatic logic [15:0] w16(input logic [9:0] v);
    return {v, v[9:4]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idx_write(input logic [31:0] w);
    @(negedge clk); idx_we = 1'b1; wdata = w;
    @(negedge clk); idx_we = 1'b0;
  endtask

  task automatic data_write(input logic [31:0] w);
    @(negedge clk); data_we = 1'b1; wdata = w;
    @(negedge clk); data_we = 1'b0;
  endtask

  task automatic max_write(input logic [1:0] s, input logic [15:0] v);
    @(negedge clk); max_we = 1'b1; max_sel = s; wdata = {16'h0, v};
    @(negedge clk); max_we = 1'b0;
  endtask

  task automatic pix_read(input logic [IW-1:0] a, input logic ov);
    @(negedge clk); pix_req = 1'b1; pix_addr = a; pix_over = ov;
    @(negedge clk); pix_req = 1'b0; pix_over = 1'b0;
  endtask

  task automatic check_rgb(input string req, input logic [31:0] w);
    check({req, " red"},   {16'h0, pix_red},   {16'h0, w16(w[29:20])});
    check({req, " green"}, {16'h0, pix_green}, {16'h0, w16(w[19:10])});
    check({req, " blue"},  {16'h0, pix_blue},  {16'h0, w16(w[9:0])});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; legacy_mode = 1'b0; idx_we = 1'b0; data_we = 1'b0;
    max_we = 1'b0; max_sel = 2'd0; wdata = '0; pix_req = 1'b0;
    pix_addr = '0; pix_over = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11: reset state
    check("R11 index", {24'h0, host_index}, 32'h0);
    check("R11 valid", {31'h0, pix_valid}, 32'h0);
    // R7: maxima reset to all ones
    pix_read(8'd0, 1'b1);
    check("R7 reset red", {16'h0, pix_red}, 32'hFFFF);
    check("R7 reset green", {16'h0, pix_green}, 32'hFFFF);
    check("R7 reset blue", {16'h0, pix_blue}, 32'hFFFF);

    // vector table: streamed with auto-increment from address 16 (R1, R2)
    idx_write(32'd16);
    idx_write(32'h4000_0000);
    for (int i = 0; i < NV; i++) data_write(VEC[i]);
    check("R2 advance", {24'h0, host_index}, 32'(16 + NV));
    for (int i = 0; i < NV; i++) begin
      pix_read(IW'(16 + i), 1'b0);
      check("R9 valid", {31'h0, pix_valid}, 32'h1);
      check_rgb("R1 unpack", VEC[i]);
    end
    @(negedge clk);
    check("R9 idle", {31'h0, pix_valid}, 32'h0);

    // R3: auto-increment write keeps stored address
    idx_write(32'd5);
    idx_write(32'h4000_0009);
    check("R3 quirk", {24'h0, host_index}, 32'd5);

    // R2: no step without auto-increment
    idx_write(32'd7);
    data_write(32'h0000_0155);
    check("R2 hold", {24'h0, host_index}, 32'd7);

    // R5: degamma region wrap
    idx_write(32'h8000_007F);
    idx_write(32'hC000_0000);
    data_write(32'h0040_2010);
    check("R5 degamma wrap", {24'h0, host_index}, 32'd0);
    pix_read(8'd127, 1'b0);
    check_rgb("R4 degamma last", 32'h0040_2010);

    // R5: gamma region wrap
    idx_write(32'h8000_00FF);
    idx_write(32'hC000_0000);
    data_write(32'h0000_0001);
    check("R5 gamma wrap", {24'h0, host_index}, 32'd128);

    // R4: gamma region start steps upward
    data_write(32'h0000_0002);
    check("R4 gamma step", {24'h0, host_index}, 32'd129);

    // R5: whole-table wrap with split off
    idx_write(32'd255);
    idx_write(32'h4000_0000);
    data_write(32'h0000_0003);
    check("R5 table wrap", {24'h0, host_index}, 32'd0);

    // R6: zero write clears flags
    data_write(32'h0000_0004);
    idx_write(32'h0);
    data_write(32'h0000_0005);
    check("R6 zero clears", {24'h0, host_index}, 32'd0);

    // R8: legacy packing and split ignored
    legacy_mode = 1'b1;
    idx_write(32'h8000_0003);
    data_write(32'h00FF_8001);
    pix_read(8'd3, 1'b0);
    check("R8 legacy red", {16'h0, pix_red}, 32'hFFFF);
    check("R8 legacy green", {16'h0, pix_green}, 32'h80A0);
    check("R8 legacy blue", {16'h0, pix_blue}, 32'h0100);
    idx_write(32'h8000_007F);
    idx_write(32'hC000_0000);
    data_write(32'h0000_0000);
    check("R8 legacy no split", {24'h0, host_index}, 32'd128);
    legacy_mode = 1'b0;
    idx_write(32'h0);

    // R7: per-channel maxima
    max_write(2'd1, 16'h1234);
    max_write(2'd3, 16'h5555);
    pix_read(8'd3, 1'b1);
    check("R7 max red", {16'h0, pix_red}, 32'hFFFF);
    check("R7 max green", {16'h0, pix_green}, 32'h1234);
    check("R7 max blue", {16'h0, pix_blue}, 32'hFFFF);
    max_write(2'd2, 16'h0ABC);
    pix_read(8'd3, 1'b1);
    check("R7 max blue set", {16'h0, pix_blue}, 32'h0ABC);

    // R10: read during write returns old data
    idx_write(32'd40);
    data_write(32'h0010_0401);
    @(negedge clk);
    data_we = 1'b1; wdata = 32'h3FF0_0000;
    pix_req = 1'b1; pix_addr = 8'd40; pix_over = 1'b0;
    @(negedge clk);
    data_we = 1'b0; pix_req = 1'b0;
    check_rgb("R10 old data", 32'h0010_0401);
    pix_read(8'd40, 1'b0);
    check_rgb("R10 new data", 32'h3FF0_0000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule